// File: doc/BRIEF.md
# Stereo Ramped Attenuator with Mute and Zero-Cross Stepping

This block scales a stereo stream of 24-bit two's-complement samples by a digital gain chosen separately for each channel. A new sample pair arrives with a one-cycle strobe. Each scaled pair is registered in the clock cycle after that strobe. Each channel has a 6-bit target level code and a mute input. The level the block actually applies never jumps to the target. It walks toward the target one 1 dB step at a time, so volume changes and muting make no audible click.

By default a step is taken on every eighth strobe. With zero-cross stepping enabled, a step that is due waits until that channel's waveform crosses zero, so the gain changes where the signal is small. A timeout keeps a silent or DC channel from blocking the ramp. When both channels are ready on the same sample, they take turns. The right channel can also be inverted in polarity at the output.

Top module: `stereo_ramp_atten`

## Requirements
- R1: The applied level code 63 passes samples unchanged. A code k from 1 to 62 gives (63-k) dB of attenuation: the output is floor(x*G/65536), where G = round(65536*10^(-(63-k)/20)). Code 0 outputs exactly zero.
- R2: With zero-cross stepping off, the applied level moves one code toward the target on each strobe whose count since reset is a multiple of 8 (strobe 8, 16, ...). The new level takes effect from the following strobe.
- R3: When a channel's mute input is high, that channel's target is code 0, and the output ramps down to exactly zero. Clearing mute ramps the level back up to the programmed code at the same rate.
- R4: After reset, both applied levels are 63, both outputs are zero, and the strobe count is zero.
- R5: The outputs update only in the clock cycle after a strobe. They hold their value while no strobe arrives.
- R6: With zero-cross stepping on, a step becomes pending on a strobe whose count is a multiple of 8. It is taken on a later strobe whose sample crosses zero. A crossing means the sample is zero, or its sign bit differs from the previous sample's. The new level applies from the next strobe.
- R7: With zero-cross stepping on and no crossing, a pending step is taken on the 512th strobe after it became pending.
- R8: With zero-cross stepping on, the two channels never step on the same strobe. On a tie, the channel that did not take the last zero-cross step goes first.
- R9: The right-invert input negates the right output after scaling. The result saturates to the 24-bit range, so -8388608 inverted gives 8388607. The left output is never inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| l_in | input | 24 | Left sample, two's complement |
| r_in | input | 24 | Right sample, two's complement |
| l_level | input | 6 | Left target level code (63 = 0 dB) |
| r_level | input | 6 | Right target level code (63 = 0 dB) |
| l_mute | input | 1 | Left mute request |
| r_mute | input | 1 | Right mute request |
| zc_en | input | 1 | Enables zero-cross aligned stepping |
| r_invert | input | 1 | Negates the right output |
| l_out | output | 24 | Scaled left sample |
| r_out | output | 24 | Scaled right sample |

## Verification
The assertions take for granted that the strobe is a single-cycle pulse. They also assume the sample inputs are stable in the strobe cycle, and that the target codes and mode inputs change only between strobes. The bench changes every input on a falling clock edge. It raises the strobe for exactly one cycle and then lowers it, and it changes control inputs only in the idle cycles between strobes. The zero-cross tests use constant positive or negative samples, so a crossing happens only where the bench places one.

// File: rtl/att_pkg.sv
package att_pkg;
  localparam int SMP_W   = 24;
  localparam int LVL_W   = 6;
  localparam int GAIN_W  = 17;
  localparam int GAIN_FR = 16;

  // gain for a given attenuation in dB, rounded to GAIN_FR fraction bits
  function automatic logic [GAIN_W-1:0] db_gain(input int db);
    real g;
    g = (2.0 ** GAIN_FR) * (10.0 ** (-(real'(db)) / 20.0));
    return GAIN_W'($rtoi(g + 0.5));
  endfunction
endpackage

// File: rtl/att_gain_rom.sv
module att_gain_rom
  import att_pkg::*;
#(
  parameter int LW = LVL_W,
  parameter int GW = GAIN_W
) (
  input  logic [LW-1:0] lvl,
  output logic [GW-1:0] gain
);
  localparam int N = 2 ** LW;

  logic [GW-1:0] tab [N];

  for (genvar k = 0; k < N; k++) begin : g_tab
    if (k == 0) begin : g_mute
      assign tab[k] = '0;
    end else begin : g_db
      localparam logic [GW-1:0] G = db_gain(N - 1 - k);
      assign tab[k] = G;
    end
  end

  assign gain = tab[lvl];
endmodule

// File: rtl/att_scale.sv
module att_scale
  import att_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int GW = GAIN_W,
  parameter int GF = GAIN_FR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [SW-1:0] din,
  input  logic [GW-1:0] gain,
  input  logic          inv,
  output logic [SW-1:0] dout
);
  localparam int PW = SW + GW + 1;

  logic signed [PW-1:0] prod, shv, val;
  logic        [SW-1:0] sat, dout_d;
  logic                 fits;

  always_comb begin
    prod = PW'($signed(din)) * $signed({1'b0, gain});
    shv  = prod >>> GF;
    val  = inv ? -shv : shv;
    fits = (val[PW-1:SW-1] == '0) || (val[PW-1:SW-1] == '1);
    if (fits)            sat = val[SW-1:0];
    else if (val[PW-1])  sat = {1'b1, {(SW-1){1'b0}}};
    else                 sat = {1'b0, {(SW-1){1'b1}}};
    dout_d = stb ? sat : dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= dout_d;
  end

  // R3: zero gain forces a silent output
  p_mute_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && gain == '0) |=> (dout == '0));
  // R1: unity gain without invert passes the sample unchanged
  p_unity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && gain == GW'(1 << GF) && !inv) |=> (dout == $past(din)));
  // R5: output holds between strobes
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(dout));
endmodule

// File: rtl/att_ramp.sv
module att_ramp
  import att_pkg::*;
#(
  parameter int SW  = SMP_W,
  parameter int LW  = LVL_W,
  parameter int TMO = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          tick,
  input  logic          zc_en,
  input  logic [LW-1:0] tgt,
  input  logic [SW-1:0] din,
  input  logic          grant,
  output logic          want,
  output logic          stepped,
  output logic [LW-1:0] lvl
);
  localparam int WW = $clog2(TMO);
  localparam logic [WW-1:0] WMAX = WW'(TMO - 1);

  logic [LW-1:0] cur_q, cur_d;
  logic          pend_q, pend_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          psgn_q, psgn_d;
  logic          diff, xing, step;

  always_comb begin
    diff    = (cur_q != tgt);
    xing    = (din == '0) || (din[SW-1] != psgn_q);
    want    = zc_en && pend_q && diff && (xing || wait_q == WMAX);
    step    = stb && diff && (zc_en ? (want && grant) : tick);
    cur_d   = cur_q;
    pend_d  = pend_q;
    wait_d  = wait_q;
    psgn_d  = stb ? din[SW-1] : psgn_q;
    if (step) cur_d = (tgt > cur_q) ? cur_q + 1'b1 : cur_q - 1'b1;
    if (!zc_en) begin
      pend_d = 1'b0;
    end else if (stb) begin
      if (step || !diff) begin
        pend_d = 1'b0;
      end else if (!pend_q && tick) begin
        pend_d = 1'b1;
        wait_d = '0;
      end else if (pend_q && wait_q != WMAX) begin
        wait_d = wait_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '1;
      pend_q <= 1'b0;
      wait_q <= '0;
      psgn_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      pend_q <= pend_d;
      wait_q <= wait_d;
      psgn_q <= psgn_d;
    end
  end

  assign lvl     = cur_q;
  assign stepped = step;

  // R2: level moves by at most one code per clock
  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, lvl} == {1'b0, $past(lvl)} ||
              {1'b0, lvl} == {1'b0, $past(lvl)} + 1'b1 ||
              {1'b0, lvl} + 1'b1 == {1'b0, $past(lvl)}));
  // R2: level changes only on a strobe
  p_level_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(lvl));
endmodule

// File: rtl/stereo_ramp_atten.sv
module stereo_ramp_atten
  import att_pkg::*;
#(
  parameter int SW  = SMP_W,
  parameter int LW  = LVL_W,
  parameter int GW  = GAIN_W,
  parameter int GF  = GAIN_FR,
  parameter int IVL = 8,
  parameter int TMO = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic [SW-1:0] l_in,
  input  logic [SW-1:0] r_in,
  input  logic [LW-1:0] l_level,
  input  logic [LW-1:0] r_level,
  input  logic          l_mute,
  input  logic          r_mute,
  input  logic          zc_en,
  input  logic          r_invert,
  output logic [SW-1:0] l_out,
  output logic [SW-1:0] r_out
);
  localparam int CW = (IVL > 1) ? $clog2(IVL) : 1;
  localparam int NCH = 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          turn_q, turn_d;
  logic          tick;

  logic [SW-1:0] din  [NCH];
  logic [SW-1:0] dout [NCH];
  logic [LW-1:0] tgt  [NCH];
  logic [LW-1:0] lvl  [NCH];
  logic [GW-1:0] gain [NCH];
  logic [NCH-1:0] want, grant, st, inv;

  assign din[0] = l_in;
  assign din[1] = r_in;
  assign tgt[0] = l_mute ? '0 : l_level;
  assign tgt[1] = r_mute ? '0 : r_level;
  assign inv    = {r_invert, 1'b0};
  assign l_out  = dout[0];
  assign r_out  = dout[1];

  always_comb begin
    tick     = (cnt_q == CW'(IVL - 1));
    cnt_d    = smp_stb ? (tick ? '0 : cnt_q + 1'b1) : cnt_q;
    grant[0] = !turn_q || !want[1];
    grant[1] =  turn_q || !want[0];
    turn_d   = turn_q;
    if (st[0])      turn_d = 1'b1;
    else if (st[1]) turn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      turn_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      turn_q <= turn_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    att_ramp #(.SW(SW), .LW(LW), .TMO(TMO)) i_ramp (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .tick(tick), .zc_en(zc_en),
      .tgt(tgt[c]), .din(din[c]), .grant(grant[c]), .want(want[c]),
      .stepped(st[c]), .lvl(lvl[c]));
    att_gain_rom #(.LW(LW), .GW(GW)) i_rom (.lvl(lvl[c]), .gain(gain[c]));
    att_scale #(.SW(SW), .GW(GW), .GF(GF)) i_scale (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .din(din[c]), .gain(gain[c]),
      .inv(inv[c]), .dout(dout[c]));
  end

  // R8: in zero-cross mode at most one channel steps per cycle
  p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zc_en |-> $onehot0(st));
endmodule

// File: tb/test_stereo_ramp_atten.sv
`timescale 1ns/1ps
module test_stereo_ramp_atten;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_stb;
  logic [23:0] l_in, r_in;
  logic [5:0]  l_level, r_level;
  logic        l_mute, r_mute, zc_en, r_invert;
  logic [23:0] l_out, r_out;

  int n_chk = 0, n_bad = 0, nstb = 0;
  int cur_l = 63, cur_r = 63;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stereo_ramp_atten i_stereo_ramp_atten (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .l_in(l_in), .r_in(r_in),
    .l_level(l_level), .r_level(r_level), .l_mute(l_mute), .r_mute(r_mute),
    .zc_en(zc_en), .r_invert(r_invert), .l_out(l_out), .r_out(r_out));

  function automatic longint gainf(int lv);
    if (lv == 0) return 0;
    return longint'($rtoi(65536.0 * (10.0 ** (-(real'(63 - lv)) / 20.0)) + 0.5));
  endfunction

  function automatic logic [23:0] expo(logic [23:0] x, int lv, bit inv);
    longint p;
    p = longint'($signed(x)) * gainf(lv);
    p = p >>> 16;
    if (inv) p = -p;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p[23:0];
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (strobe %0d)", req, act, exp, nstb);
    end
  endtask

  function automatic int tgt_of(int lv, bit m);
    return m ? 0 : lv;
  endfunction

  // one strobe; outputs sampled on the falling edge after the capture edge
  task automatic do_stb(logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    l_in = l; r_in = r; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    nstb++;
    if (model_on) begin
      check("R2/R3 left", l_out, expo(l, cur_l, 1'b0));
      check("R2/R3 right", r_out, expo(r, cur_r, r_invert));
      if (nstb % 8 == 0) begin
        if (cur_l < tgt_of(l_level, l_mute)) cur_l++;
        else if (cur_l > tgt_of(l_level, l_mute)) cur_l--;
        if (cur_r < tgt_of(r_level, r_mute)) cur_r++;
        else if (cur_r > tgt_of(r_level, r_mute)) cur_r--;
      end
    end
  endtask

  // {sample, invert, expected right output} at unity gain
  localparam logic [48:0] VEC [8] = '{
    {24'h000001, 1'b0, 24'h000001},
    {24'h7FFFFF, 1'b1, 24'h800001},
    {24'h800000, 1'b1, 24'h7FFFFF},
    {24'h123456, 1'b0, 24'h123456},
    {24'hFFFFFF, 1'b1, 24'h000001},
    {24'h000000, 1'b1, 24'h000000},
    {24'h400000, 1'b1, 24'hC00000},
    {24'h800000, 1'b0, 24'h800000}
  };

  localparam logic [23:0] P = 24'h400000;
  localparam logic [23:0] N = 24'hC00000;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first;
    logic [23:0] old;
    rst_n = 1'b0; smp_stb = 1'b0; l_in = '0; r_in = '0;
    l_level = 6'd63; r_level = 6'd63; l_mute = 1'b0; r_mute = 1'b0;
    zc_en = 1'b0; r_invert = 1'b0;
    repeat (3) @(negedge clk);
    // R4: reset state
    check("R4 left reset", l_out, 24'h0);
    check("R4 right reset", r_out, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 left after release", l_out, 24'h0);

    // R1/R9: vector table at unity level
    for (int i = 0; i < 8; i++) begin
      r_invert = VEC[i][24];
      do_stb(VEC[i][48:25], VEC[i][48:25]);
      check("R1 left unity", l_out, VEC[i][48:25]);
      check("R9 right invert", r_out, VEC[i][23:0]);
    end
    r_invert = 1'b0;

    // R5: outputs hold without strobes
    l_in = 24'h055555;
    repeat (4) @(negedge clk);
    check("R5 hold", l_out, 24'h800000);

    // R2/R1: ramp to level 60 with per-strobe model
    model_on = 1'b1;
    l_level = 6'd60;
    repeat (48) do_stb(P, N);
    check("R2 reached 60", l_out, expo(P, 60, 1'b0));

    // R3: mute ramps to exact zero, unmute ramps back
    l_mute = 1'b1;
    repeat (8 * 62) do_stb(P, P);
    check("R3 muted zero", l_out, 24'h0);
    l_mute = 1'b0;
    repeat (8 * 62) do_stb(N, P);
    check("R3 unmuted level 60", l_out, expo(N, 60, 1'b0));
    model_on = 1'b0;

    // R7: timeout step with no crossing (positive samples only)
    zc_en = 1'b1;
    do_stb(P, P);
    old = l_out;
    l_level = 6'd59;
    first = 0;
    for (int i = 1; i <= 540; i++) begin
      do_stb(P, P);
      if (first == 0 && l_out != old) first = i;
    end
    n_chk++;
    if (first < 513 || first > 530) begin
      n_bad++;
      $display("FAIL R7 timeout: actual step after %0d strobes expected 513..530", first);
    end
    check("R7 level 59", l_out, expo(P, 59, 1'b0));

    // R6: step waits for a crossing, then applies from the next strobe
    l_level = 6'd58;
    repeat (12) do_stb(P, P);
    check("R6 no crossing holds", l_out, expo(P, 59, 1'b0));
    do_stb(N, N);
    check("R6 crossing strobe old level", l_out, expo(N, 59, 1'b0));
    do_stb(N, N);
    check("R6 new level after crossing", l_out, expo(N, 58, 1'b0));

    // R8: tie goes to the right (left took the last step)
    l_level = 6'd57; r_level = 6'd62;
    repeat (12) do_stb(N, N);
    check("R8 left pending", l_out, expo(N, 58, 1'b0));
    check("R8 right pending", r_out, expo(N, 63, 1'b0));
    do_stb(P, P);
    do_stb(P, P);
    check("R8 left waits", l_out, expo(P, 58, 1'b0));
    check("R8 right first", r_out, expo(P, 62, 1'b0));
    do_stb(N, N);
    do_stb(N, N);
    check("R8 left second", l_out, expo(N, 57, 1'b0));
    check("R8 right stays", r_out, expo(N, 62, 1'b0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule